// File: doc/BRIEF.md
# Graphics Write Rotate, Logic and Mask Unit

This unit sits between the host's write-data register and a 16-bit display RAM port. It turns every host write into an internal read-modify-write, so that the host never has to fetch the stored word. When a write is accepted, the unit reads the target address. In the next cycle it takes the stored word from the RAM read-data path and does three things in one pass:

- It rotates the host word toward the least significant bit by a programmed count.
- It combines the rotated word with the stored word using one of four logic operations.
- It applies a per-bit protection mask, and writes the result back to the same address.

The rotate count, the operation code and the mask are sampled when the write is accepted. The unit drops `host_ready` for one cycle per write, so a new write is accepted at most every second cycle. This spacing means each read sees the result of the previous write. With rotate 0, replace mode and an all-zero mask, host data passes to RAM unchanged.

Top module: `gfx_rmw_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `host_ready` is 1 and neither `ram_rd_en` nor `ram_wr_en` is asserted.
- R2: In a cycle where `host_wr_valid` and `host_ready` are both 1 (an accept), `ram_rd_en` is 1 and `ram_rd_addr` equals `host_wr_addr` in that same cycle.
- R3: Exactly one cycle after an accept, `ram_wr_en` is 1 with `ram_wr_addr` equal to the accepted address, and `host_ready` is 0 in that cycle. `ram_wr_en` is never asserted at any other time.
- R4: The host word is rotated toward the LSB by `rot_amt` (0 to 15) with wrap-around: bit i of the rotated word equals host bit (i + rot_amt) mod 16.
- R5: `op_sel` selects how the rotated word R and the stored word S are combined: 2'b00 gives R, 2'b01 gives R OR S, 2'b10 gives R AND S, 2'b11 gives R XOR S.
- R6: A `wr_mask` bit of 1 makes the written bit equal the stored bit. A mask bit of 0 lets the combined result through.
- R7: The stored word is the value on `ram_rd_data` in the write cycle, which is the cycle after the read request (synchronous RAM with one cycle of read latency).
- R8: `rot_amt`, `op_sel`, `wr_mask` and the host data are sampled at the accept. Changing them in the write cycle has no effect on the written word.
- R9: With `rot_amt` 0, `op_sel` 2'b00 and `wr_mask` all zero, the written word equals the host word.
- R10: While `host_wr_valid` is 0, no RAM read is requested, and no RAM write follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_valid | input | 1 | Host write request |
| host_wr_addr | input | AW | Host target address |
| host_wr_data | input | DW | Host write word |
| host_ready | output | 1 | Unit can accept a write this cycle |
| rot_amt | input | $clog2(DW) | Rotate count toward the LSB |
| op_sel | input | 2 | Logic operation code |
| wr_mask | input | DW | Per-bit protection mask (1 = keep stored bit) |
| ram_rd_en | output | 1 | RAM read request |
| ram_rd_addr | output | AW | RAM read address |
| ram_rd_data | input | DW | RAM read data, valid one cycle after the request |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_addr | output | AW | RAM write address |
| ram_wr_data | output | DW | Word written to RAM |

## Verification
The bench builds the unit with DW = 16 and AW = 4, and keeps the log-stage rotator selected. A 16-word RAM lets repeated writes to the same addresses stack up logic results on earlier results. This exercises the read-after-write spacing. With a 4-bit rotate count, every rotation 0 to 15 is reachable, and so is every stage combination of the barrel network. The bench sweeps all of them and all four operations. It also uses random masks and changes the configuration during the write cycle.

// File: rtl/gfx_rmw_pkg.sv
package gfx_rmw_pkg;
  typedef enum logic [1:0] {
    OP_COPY = 2'b00,
    OP_SET  = 2'b01,
    OP_KEEP = 2'b10,
    OP_FLIP = 2'b11
  } gfx_op_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_COMMIT = 1'b1
  } rmw_state_e;
endpackage

// File: rtl/gfx_rot_right.sv
module gfx_rot_right #(
  parameter int DW         = 16,
  parameter int CW         = $clog2(DW),
  parameter bit LOG_STAGES = 1'b1
) (
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] amt,
  output logic [DW-1:0] dout
);
  generate
    if (LOG_STAGES) begin : g_log
      // One stage per count bit; stage s rotates by 2**s when its bit is set.
      logic [DW-1:0] stg [0:CW];
      assign stg[0] = din;
      for (genvar s = 0; s < CW; s++) begin : g_stage
        localparam int SH = 2 ** s;
        assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][DW-1:SH]} : stg[s];
      end
      assign dout = stg[CW];
    end else begin : g_flat
      logic [2*DW-1:0] dbl;
      always_comb begin
        dbl  = {din, din} >> amt;
        dout = dbl[DW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/gfx_logic_op.sv
module gfx_logic_op
  import gfx_rmw_pkg::*;
#(
  parameter int DW = 16
) (
  input  gfx_op_e       op,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (op)
      OP_COPY: res = src;
      OP_SET:  res = src | dst;
      OP_KEEP: res = src & dst;
      OP_FLIP: res = src ^ dst;
      default: res = src;
    endcase
  end
endmodule

// File: rtl/gfx_mask_merge.sv
module gfx_mask_merge #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] keep,
  input  logic [DW-1:0] stored,
  input  logic [DW-1:0] fresh,
  output logic [DW-1:0] merged
);
  // A keep bit of 1 holds the stored value.
  always_comb merged = (keep & stored) | (~keep & fresh);
endmodule

// File: rtl/gfx_rmw_unit.sv
module gfx_rmw_unit
  import gfx_rmw_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 4,
  parameter bit LOG_STAGES = 1'b1,
  localparam int CW        = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_valid,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [DW-1:0] host_wr_data,
  output logic          host_ready,
  input  logic [CW-1:0] rot_amt,
  input  logic [1:0]    op_sel,
  input  logic [DW-1:0] wr_mask,
  output logic          ram_rd_en,
  output logic [AW-1:0] ram_rd_addr,
  input  logic [DW-1:0] ram_rd_data,
  output logic          ram_wr_en,
  output logic [AW-1:0] ram_wr_addr,
  output logic [DW-1:0] ram_wr_data
);
  rmw_state_e    state_q, state_d;
  logic          accept;
  logic          cap_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] rot_q;
  gfx_op_e       op_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] rotated;
  logic [DW-1:0] combined;

  // Control: ready only while idle, so each write occupies two cycles.
  always_comb begin
    host_ready = (state_q == ST_IDLE);
    accept     = host_wr_valid && host_ready;
    cap_en     = accept;
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Operand capture at accept, with a written-out enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      rot_q  <= '0;
      op_q   <= OP_COPY;
      mask_q <= '0;
    end else if (cap_en) begin
      addr_q <= host_wr_addr;
      data_q <= host_wr_data;
      rot_q  <= rot_amt;
      op_q   <= gfx_op_e'(op_sel);
      mask_q <= wr_mask;
    end
  end

  // Read request issued in the accept cycle.
  always_comb begin
    ram_rd_en   = accept;
    ram_rd_addr = host_wr_addr;
  end

  gfx_rot_right #(.DW(DW), .CW(CW), .LOG_STAGES(LOG_STAGES)) u_rot (
    .din  (data_q),
    .amt  (rot_q),
    .dout (rotated)
  );

  gfx_logic_op #(.DW(DW)) u_op (
    .op  (op_q),
    .src (rotated),
    .dst (ram_rd_data),
    .res (combined)
  );

  gfx_mask_merge #(.DW(DW)) u_mask (
    .keep   (mask_q),
    .stored (ram_rd_data),
    .fresh  (combined),
    .merged (ram_wr_data)
  );

  always_comb begin
    ram_wr_en   = (state_q == ST_COMMIT);
    ram_wr_addr = addr_q;
  end
endmodule

// File: rtl/gfx_rmw_chk.sv
module gfx_rmw_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr_valid,
  input logic [AW-1:0] host_wr_addr,
  input logic          host_ready,
  input logic [DW-1:0] wr_mask,
  input logic          ram_rd_en,
  input logic [AW-1:0] ram_rd_addr,
  input logic [DW-1:0] ram_rd_data,
  input logic          ram_wr_en,
  input logic [AW-1:0] ram_wr_addr,
  input logic [DW-1:0] ram_wr_data
);
  p_rd_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && host_ready) |-> (ram_rd_en && ram_rd_addr == host_wr_addr));

  p_wr_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && host_ready) |=> (ram_wr_en && ram_wr_addr == $past(host_wr_addr)));

  p_wr_needs_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> $past(host_wr_valid && host_ready));

  p_busy_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> !host_ready);

  p_mask_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> (((ram_wr_data ^ ram_rd_data) & $past(wr_mask)) == '0));

  p_no_read_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_valid |-> !ram_rd_en);
endmodule

bind gfx_rmw_unit gfx_rmw_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/test_gfx_rmw_unit.sv
module test_gfx_rmw_unit;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int CW = 4;
  localparam int NW = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          host_wr_valid;
  logic [AW-1:0] host_wr_addr;
  logic [DW-1:0] host_wr_data;
  logic          host_ready;
  logic [CW-1:0] rot_amt;
  logic [1:0]    op_sel;
  logic [DW-1:0] wr_mask;
  logic          ram_rd_en;
  logic [AW-1:0] ram_rd_addr;
  logic [DW-1:0] ram_rd_data;
  logic          ram_wr_en;
  logic [AW-1:0] ram_wr_addr;
  logic [DW-1:0] ram_wr_data;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] ram_mem   [NW];
  logic [DW-1:0] model_mem [NW];
  logic [AW+DW-1:0] exp_q [$];

  gfx_rmw_unit #(.DW(DW), .AW(AW)) i_gfx_rmw_unit (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Synchronous RAM with one cycle read latency (R7).
  always @(posedge clk) begin
    if (ram_rd_en) ram_rd_data <= ram_mem[ram_rd_addr];
    if (ram_wr_en) ram_mem[ram_wr_addr] <= ram_wr_data;
  end

  function automatic logic [DW-1:0] rot_model(input logic [DW-1:0] d, input int n);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = d[(i + n) % DW];
    return r;
  endfunction

  function automatic logic [DW-1:0] expect_word(input logic [DW-1:0] d, input int n,
                                                input logic [1:0] op, input logic [DW-1:0] m,
                                                input logic [DW-1:0] s);
    logic [DW-1:0] r, c;
    r = rot_model(d, n);
    case (op)
      2'b00: c = r;
      2'b01: c = r | s;
      2'b10: c = r & s;
      default: c = r ^ s;
    endcase
    return (m & s) | (~m & c);
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: waits for ready, drives one write, pushes the expected RAM write.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n,
                          input logic [1:0] op, input logic [DW-1:0] m, input bit scramble);
    logic [DW-1:0] e;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_wr_valid = 1'b1;
    host_wr_addr  = a;
    host_wr_data  = d;
    rot_amt       = CW'(n);
    op_sel        = op;
    wr_mask       = m;
    e = expect_word(d, n, op, m, model_mem[a]);
    model_mem[a] = e;
    exp_q.push_back({a, e});
    #1;
    check(ram_rd_en && ram_rd_addr == a, "R2 read on accept",
          DW'(ram_rd_addr), DW'(a));
    @(negedge clk);
    host_wr_valid = 1'b0;
    if (scramble) begin
      // R8: configuration changes during the write cycle must not matter.
      host_wr_data = ~d;
      rot_amt      = CW'(n + 5);
      op_sel       = op ^ 2'b11;
      wr_mask      = ~m;
    end
  endtask

  // Monitor: pops the scoreboard on every RAM write.
  always @(negedge clk) begin
    if (rst_n && ram_wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected write", ram_wr_data, '0);
      end else begin
        logic [AW+DW-1:0] it;
        it = exp_q.pop_front();
        check(ram_wr_addr == it[AW+DW-1:DW], "R3 write address",
              DW'(ram_wr_addr), DW'(it[AW+DW-1:DW]));
        check(ram_wr_data == it[DW-1:0], "R4/R5/R6/R7/R8 write data",
              ram_wr_data, it[DW-1:0]);
        check(!host_ready, "R3 ready low while writing", DW'(host_ready), '0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      ram_mem[i]   = DW'(16'h1234 * (i + 1));
      model_mem[i] = DW'(16'h1234 * (i + 1));
    end
    rst_n = 1'b0;
    host_wr_valid = 1'b0;
    host_wr_addr = '0;
    host_wr_data = '0;
    rot_amt = '0;
    op_sel = 2'b00;
    wr_mask = '0;
    ram_rd_data = '0;
    repeat (3) @(negedge clk);
    check(host_ready && !ram_rd_en && !ram_wr_en, "R1 reset state",
          DW'({host_ready, ram_rd_en, ram_wr_en}), DW'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    check(host_ready && !ram_rd_en && !ram_wr_en, "R1 after reset",
          DW'({host_ready, ram_rd_en, ram_wr_en}), DW'(3'b100));

    // R9 passthrough
    do_write(4'd0, 16'hBEEF, 0, 2'b00, 16'h0000, 1'b0);
    do_write(4'd1, 16'h0001, 0, 2'b00, 16'h0000, 1'b0);

    // R4 every rotation
    for (int n = 0; n < 16; n++) do_write(AW'(n), 16'h8421 ^ DW'(n), n, 2'b00, 16'h0000, 1'b0);

    // R5 each operation, stacking on the same address
    for (int op = 0; op < 4; op++) do_write(4'd3, 16'hF0A5, op, 2'(op), 16'h0000, 1'b0);

    // R6 masks
    do_write(4'd5, 16'hFFFF, 0, 2'b00, 16'hFF00, 1'b0);
    do_write(4'd5, 16'h0000, 0, 2'b00, 16'h0F0F, 1'b0);
    do_write(4'd6, 16'h1234, 7, 2'b11, 16'hFFFF, 1'b0);

    // R8 configuration scrambled in write cycle
    for (int k = 0; k < 6; k++)
      do_write(AW'(k + 8), DW'($urandom), k * 3, 2'(k), DW'($urandom), 1'b1);

    // R10 idle: no reads or writes
    @(negedge clk);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(!ram_rd_en && !ram_wr_en, "R10 idle quiet",
            DW'({ram_rd_en, ram_wr_en}), '0);
      @(negedge clk);
    end

    // random mix, R4 R5 R6 R7
    for (int k = 0; k < 200; k++)
      do_write(AW'($urandom), DW'($urandom), int'($urandom % 16), 2'($urandom),
               DW'($urandom), k[0]);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all writes committed", DW'(exp_q.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule